// File: doc/BRIEF.md
# Floating-Point Relational Comparator

This block compares two IEEE-754 binary operands of one configurable width (16, 32, 64 or 128 bits) and produces all six ordering predicates at once: less-than, equal, not-equal, less-or-equal, greater-than and greater-or-equal. It works directly on the raw encodings. The two sign bits and an unsigned compare of the whole word set the order. Positive and negative zero count as the same value. NaN encodings get no special treatment: they are ordered by their bit patterns like any other word, and the block raises no exception flags.

The width parameter fixes the exponent and mantissa split used for zero detection: 5/10 for 16 bits, 8/23 for 32 bits, 11/52 for 64 bits and 15/112 for 128 bits. With `PIPE` set to 1, which is the default, a single register stage captures the predicates whenever `in_valid` is high. `out_valid` reports the capture one cycle later, and the outputs keep their value while no new operands arrive. With `PIPE` set to 0 the predicates and the valid bit pass straight through with no clock involved.

Top module: `fpcmp_top`

## Requirements
- R1: `eq` is 1 when the two operand words are bit-identical, or when both operands are zero (bits W-2..0 all zero, sign bit at position W-1 ignored). Otherwise `eq` is 0.
- R2: When the sign bits (bit W-1) differ, `lt` is 1 exactly when `op_a` has its sign bit set and the two operands are not both zero.
- R3: When the sign bits match, `lt` is 1 exactly when the words differ and the result of the unsigned compare `op_a < op_b` differs from `op_a`'s sign bit.
- R4: `ne` is the inverse of `eq`, and `le` is `eq` OR `lt`.
- R5: `gt` is the inverse of `le`, and `ge` is the inverse of `lt`. For any pair of operands, exactly one of `lt`, `eq` and `gt` is 1.
- R6: An operand counts as zero only if both its exponent field and its mantissa field are all zero. A word with any exponent or mantissa bit set is never treated as zero.
- R7: With PIPE=1, `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid`=1 and is 0 otherwise. The predicates shown alongside it belong to the operands sampled at that edge.
- R8: While `rst_n` is low, `out_valid` and all six predicates are 0.
- R9: With PIPE=1, an edge that samples `in_valid`=0 leaves all six predicates unchanged, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are present and should be compared |
| op_a | input | W | Left operand (operand 0) |
| op_b | input | W | Right operand (operand 1) |
| out_valid | output | 1 | The predicates hold a new result |
| lt | output | 1 | op_a < op_b |
| eq | output | 1 | op_a == op_b, with the two zeros equal |
| ne | output | 1 | op_a != op_b |
| le | output | 1 | op_a <= op_b |
| gt | output | 1 | op_a > op_b |
| ge | output | 1 | op_a >= op_b |

## Verification
The assertions assume that `in_valid`, `op_a` and `op_b` carry known 0/1 values at every sampling edge after reset. They also assume the operands seen at an edge are the ones that edge captured, since the result checks recompute ordering from the operands one cycle back. The stimulus meets both assumptions: it drives every input to a defined value before reset is released and changes the inputs only on the falling clock edge. The random operands are built as near-equal same-sign pairs, mixed-sign pairs and zero-dominated pairs, so that the sign-correction and zero-equality paths are exercised far more often than uniform random words would reach them.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // exponent field width for a supported total width
  function automatic int exp_bits(input int w);
    case (w)
      16:      return 5;
      64:      return 11;
      128:     return 15;
      default: return 8;
    endcase
  endfunction

  function automatic int man_bits(input int w);
    return w - 1 - exp_bits(w);
  endfunction

  typedef struct packed {
    logic lt;
    logic eq;
    logic ne;
    logic le;
    logic gt;
    logic ge;
  } fpcmp_pred_t;

endpackage

// File: rtl/fpcmp_zero_det.sv
module fpcmp_zero_det #(
  parameter int W    = 32,
  parameter int EXPW = 8,
  parameter int MANW = 23
) (
  input  logic [W-1:0] word,
  output logic         is_zero
);
  localparam int MAN_LO = 0;
  localparam int EXP_LO = MANW;

  logic [EXPW-1:0] exp_f;
  logic [MANW-1:0] man_f;
  logic            exp_clear;
  logic            man_clear;

  always_comb begin
    exp_f     = word[EXP_LO +: EXPW];
    man_f     = word[MAN_LO +: MANW];
    exp_clear = (exp_f == '0);
    man_clear = (man_f == '0);
    is_zero   = exp_clear & man_clear;
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_zero,
  input  logic         b_zero,
  output logic         lt,
  output logic         eq
);
  localparam int SGN = W - 1;

  logic both_zero;
  logic same_word;
  logic raw_below;
  logic a_neg;
  logic sign_split;
  logic lt_split;
  logic lt_same;

  always_comb begin
    both_zero  = a_zero & b_zero;
    same_word  = (a == b);
    raw_below  = (a < b);
    a_neg      = a[SGN];
    sign_split = a[SGN] ^ b[SGN];
    lt_split   = a_neg & ~both_zero;
    lt_same    = ~same_word & (raw_below ^ a_neg);
    lt         = sign_split ? lt_split : lt_same;
    eq         = same_word | both_zero;
  end
endmodule

// File: rtl/fpcmp_pred.sv
module fpcmp_pred
  import fpcmp_pkg::*;
(
  input  logic        lt,
  input  logic        eq,
  output fpcmp_pred_t pred
);
  always_comb begin
    pred.lt = lt;
    pred.eq = eq;
    pred.ne = ~eq;
    pred.le = eq | lt;
    pred.gt = ~(eq | lt);
    pred.ge = ~lt;
  end
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top
  import fpcmp_pkg::*;
#(
  parameter int W    = 32,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic         lt,
  output logic         eq,
  output logic         ne,
  output logic         le,
  output logic         gt,
  output logic         ge
);
  localparam int EXPW = exp_bits(W);
  localparam int MANW = man_bits(W);

  logic        a_zero;
  logic        b_zero;
  logic        lt_c;
  logic        eq_c;
  fpcmp_pred_t pred_c;
  fpcmp_pred_t pred_o;
  logic        vld_o;

  fpcmp_zero_det #(.W(W), .EXPW(EXPW), .MANW(MANW)) u_zero_a (
    .word    (op_a),
    .is_zero (a_zero)
  );

  fpcmp_zero_det #(.W(W), .EXPW(EXPW), .MANW(MANW)) u_zero_b (
    .word    (op_b),
    .is_zero (b_zero)
  );

  fpcmp_order #(.W(W)) u_order (
    .a      (op_a),
    .b      (op_b),
    .a_zero (a_zero),
    .b_zero (b_zero),
    .lt     (lt_c),
    .eq     (eq_c)
  );

  fpcmp_pred u_pred (
    .lt   (lt_c),
    .eq   (eq_c),
    .pred (pred_c)
  );

  generate
    if (PIPE) begin : g_reg
      fpcmp_pred_t pred_q, pred_d;
      logic        vld_q, vld_d;
      logic        cap_en;

      always_comb begin
        cap_en = in_valid;
        vld_d  = in_valid;
        pred_d = cap_en ? pred_c : pred_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          pred_q <= '0;
        end else begin
          vld_q  <= vld_d;
          pred_q <= pred_d;
        end
      end

      always_comb begin
        vld_o  = vld_q;
        pred_o = pred_q;
      end
    end else begin : g_comb
      always_comb begin
        vld_o  = in_valid & rst_n;
        pred_o = rst_n ? pred_c : '0;
      end
    end
  endgenerate

  always_comb begin
    out_valid = vld_o;
    lt        = pred_o.lt;
    eq        = pred_o.eq;
    ne        = pred_o.ne;
    le        = pred_o.le;
    gt        = pred_o.gt;
    ge        = pred_o.ge;
  end
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int W    = 32,
  parameter bit PIPE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic         lt,
  input logic         eq,
  input logic         ne,
  input logic         le,
  input logic         gt,
  input logic         ge
);
  // exactly one ordering relation reported
  assert_one_relation_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({lt, eq, gt}) == 1));

  assert_ne_vs_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ne != eq));

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R8: assert ({out_valid, lt, eq, ne, le, gt, ge} == '0);
    end
  end

  generate
    if (PIPE) begin : g_seq
      assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

      assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
          $stable({lt, eq, ne, le, gt, ge}));

      assert_zero_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) &&
         ($past(op_a[W-2:0]) == '0) && ($past(op_b[W-2:0]) == '0)) |-> eq);

      assert_neg_below_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_a[W-1]) && !$past(op_b[W-1]) &&
         (($past(op_a[W-2:0]) != '0) || ($past(op_b[W-2:0]) != '0))) |-> lt);

      assert_pos_mag_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(op_a[W-1]) && !$past(op_b[W-1]) &&
         ($past(op_a) < $past(op_b))) |-> lt);
    end
  endgenerate
endmodule

bind fpcmp_top fpcmp_chk #(.W(W), .PIPE(PIPE)) u_fpcmp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .lt        (lt),
  .eq        (eq),
  .ne        (ne),
  .le        (le),
  .gt        (gt),
  .ge        (ge)
);

// File: tb/tb_fpcmp_top.sv
`timescale 1ns/1ps
module tb_fpcmp_top;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         out_valid, lt, eq, ne, le, gt, ge;

  int  n_run;
  int  n_fail;
  bit  done;

  fpcmp_top #(.W(W), .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .lt(lt), .eq(eq), .ne(ne), .le(le), .gt(gt), .ge(ge)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit m_zero(input logic [W-1:0] x);
    return (x[W-2:0] == '0);
  endfunction

  function automatic bit m_eq(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a == b) || (m_zero(a) && m_zero(b));
  endfunction

  function automatic bit m_lt(input logic [W-1:0] a, input logic [W-1:0] b);
    if (a[W-1] != b[W-1]) return a[W-1] && !(m_zero(a) && m_zero(b));
    return (a != b) && ((a < b) ^ a[W-1]);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b a=%h b=%h", tag, act, exp_v, op_a, op_b);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // drive on falling edge, registered result visible at the next falling edge
  task automatic compare(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    bit e, l;
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    e = m_eq(a, b);
    l = m_lt(a, b);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R7 out_valid"}, out_valid, 1'b1);
    chk({tag, " R1 eq"}, eq, e);
    chk({tag, " R2/R3 lt"}, lt, l);
    chk({tag, " R4 ne"}, ne, !e);
    chk({tag, " R4 le"}, le, e || l);
    chk({tag, " R5 gt"}, gt, !(e || l));
    chk({tag, " R5 ge"}, ge, !l);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    void'($urandom(32'h5EED_0C0F));
    repeat (3) @(negedge clk);
    // R8: cleared during reset
    chk("R8 out_valid", out_valid, 1'b0);
    chk("R8 preds", |{lt, eq, ne, le, gt, ge}, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle out_valid", out_valid, 1'b0);

    // directed corners
    compare(32'h0000_0000, 32'h8000_0000, "R1 +0 vs -0");
    compare(32'h8000_0000, 32'h0000_0000, "R2 -0 vs +0");
    compare(32'hBF80_0000, 32'h3F80_0000, "R2 -1 vs +1");
    compare(32'h3F80_0000, 32'hBF80_0000, "R2 +1 vs -1");
    compare(32'h3F80_0000, 32'h4000_0000, "R3 1 vs 2");
    compare(32'hC000_0000, 32'hBF80_0000, "R3 -2 vs -1");
    compare(32'hBF80_0000, 32'hBF80_0000, "R1 identical neg");
    compare(32'h8000_0001, 32'h0000_0000, "R6 -denorm vs +0");
    compare(32'h0080_0000, 32'h8000_0000, "R6 exp only vs -0");
    compare(32'h8000_0001, 32'h0000_0001, "R2 tiny mixed");

    // R9: idle cycle with changed operands keeps previous result
    begin
      logic [5:0] prev;
      prev = {lt, eq, ne, le, gt, ge};
      @(negedge clk);
      op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0000; in_valid = 1'b0;
      @(negedge clk);
      chk("R9 hold preds", ({lt, eq, ne, le, gt, ge} == prev), 1'b1);
      chk("R7 no valid", out_valid, 1'b0);
    end

    // random: mixed shapes
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      int kind;
      kind = $urandom_range(0, 3);
      a = $urandom;
      case (kind)
        0: b = $urandom;
        1: begin b = a ^ (32'h1 << $urandom_range(0, 30)); end
        2: begin a = {a[W-1], 31'h0}; b = {1'($urandom), 31'h0}; end
        default: begin b = {~a[W-1], a[W-2:0] + 31'($urandom_range(0, 3))}; end
      endcase
      compare(a, b, "rand");
    end
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule